// File: doc/BRIEF.md
# Per-Thread Memory Address Dependency Tracker

This block sits in front of a shared memory issue slot in a multithreaded in-order pipeline. Each hardware thread owns a small associative table of addresses that currently have an outstanding access. Each entry also holds the sequence number of the instruction that owns it. When a request arrives, the tracker answers in the same cycle with grant or deny. It denies a data access to an address that another instruction of the same thread is still using. It lets the owning instruction replay its own access. Instruction fetches pass without a table check.

Entries leave a table in two ways. A completion removes the entry by address. A squash removes every entry of a thread whose sequence number is younger than a boundary. A squash caused by a memory stall moves the boundary up by one so that the stalling instruction keeps its entry. Each thread also has a translation-blocked flag. While the flag is set, the thread receives no grants. A squash that removes the blocked instruction also drops the flag.

Top module: `addr_dep_tracker`

## Requirements
- R1: The response is combinational: for every cycle with `req_valid` high, exactly one of `grant` and `deny` is high, and with `req_valid` low both are low. The decision uses the table contents held at the start of the cycle, and a new entry becomes visible in the next cycle. After reset every table is empty, so the first data request of each thread is granted.
- R2: A data request (`req_fetch`=0) is denied when its thread's table holds an entry for the same address owned by a different sequence number.
- R3: A data request whose address matches an entry owned by the same sequence number is granted, and no second entry is created for it.
- R4: Tables are kept per thread, so the same address may be held by one entry in each thread at once.
- R5: A fetch request (`req_fetch`=1) is granted without looking at the table, even when the table is full or holds the address, and it never creates an entry.
- R6: A completion (`cmp_valid`, `cmp_tid`, `cmp_addr`) removes the entry for that address in that thread, and from the next cycle another sequence number may be granted that address.
- R7: A data request for a new address is denied when its thread already holds DEPTH entries (DEPTH=4 by default).
- R8: A squash (`sq_valid`, `sq_tid`, `sq_seq`=S, `sq_mem_stall`=0) removes the entries of thread `sq_tid` whose sequence number is greater than S. The entry owned by S itself and any older entry stay.
- R9: With `sq_mem_stall`=1 the squash boundary becomes S+1, so an entry owned by S+1 survives.
- R10: While a thread's translation-blocked flag is set, every request from that thread is denied, fetches included. `xb_set` with `xb_tid` and `xb_seq` sets the flag and records the sequence number that is waiting. `xb_clr` clears it, and `xb_set` wins if both name the same thread. The other threads are not affected.
- R11: A squash on a thread clears that thread's flag when the recorded waiting sequence number is greater than the squash's effective boundary. Otherwise the flag stays set.
- R12: If a completion and a squash both hit the same entry in one cycle, that entry is removed once and all other entries are left as they were.
- R13: A request is denied and not recorded when, in the same cycle, a squash on its thread has an effective boundary below the request's sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_tid | input | TID_W | Requesting thread |
| req_seq | input | SEQ_W | Sequence number of the requesting instruction |
| req_addr | input | ADDR_W | Address of the access |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| grant | output | 1 | Request may take the issue slot |
| deny | output | 1 | Request must retry later |
| cmp_valid | input | 1 | An access has completed |
| cmp_tid | input | TID_W | Thread of the completed access |
| cmp_addr | input | ADDR_W | Address of the completed access |
| sq_valid | input | 1 | Squash this cycle |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Squash boundary S |
| sq_mem_stall | input | 1 | Squash caused by a memory stall (boundary S+1) |
| xb_set | input | 1 | Set the translation-blocked flag of `xb_tid` |
| xb_clr | input | 1 | Clear the translation-blocked flag of `xb_tid` |
| xb_tid | input | TID_W | Thread for the flag update |
| xb_seq | input | SEQ_W | Sequence number waiting on translation |

## Verification
The main function is driven with several request patterns. Repeat requests to one address from a different sequence number show that conflicts are detected. The same sequence number repeated shows that replay is honoured. The same address from the other thread shows that the tables are kept apart. Fetches sent against a full or conflicting table show that the table is bypassed. Squashes with and without the stall flag, placed around existing owners, show whether the boundary is exclusive and whether the +1 shift is applied. Cycles that combine a completion with a squash, or a request with a squash, show how the block resolves events that arrive in the same cycle.

// File: rtl/adt_pkg.sv
// Shared types for the address dependency tracker.
// Assumes nothing beyond SystemVerilog packages.
package adt_pkg;

    // Outcome of the per-cycle request decision, in priority order.
    typedef enum logic [2:0] {
        DEC_IDLE,
        DEC_DENY_BLOCK,
        DEC_DENY_SQUASH,
        DEC_GRANT_FETCH,
        DEC_GRANT_REPLAY,
        DEC_DENY_CONFLICT,
        DEC_DENY_FULL,
        DEC_GRANT_NEW
    } adt_dec_e;

    // True for the outcomes that give the slot.
    function automatic logic dec_is_grant(adt_dec_e d);
        return (d == DEC_GRANT_FETCH) || (d == DEC_GRANT_REPLAY) ||
               (d == DEC_GRANT_NEW);
    endfunction

endpackage

// File: rtl/adt_thread_table.sv
// One thread's associative table of outstanding addresses.
// Each entry holds a valid bit, an address and an owner sequence number.
// The lookup compares all entries in one cycle. Allocation takes the lowest
// free slot. Assumes the caller allocates only when the table is not full
// and no entry matches, so each address is held at most once.
module adt_thread_table #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int SEQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [SEQ_W-1:0]  lk_seq,
    output logic              hit_same,
    output logic              hit_other,
    output logic              full,
    input  logic              alloc_en,
    input  logic              cmp_en,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic              sq_en,
    input  logic [SEQ_W-1:0]  sq_bound
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  ent_vld;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [SEQ_W-1:0]  ent_seq  [DEPTH];
    logic [DEPTH-1:0]  addr_hit;
    logic [DEPTH-1:0]  drop;
    logic [IDX_W-1:0]  free_idx;

    // Per-entry address match and removal conditions.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign addr_hit[i] = ent_vld[i] && (ent_addr[i] == lk_addr);
        assign drop[i]     = ent_vld[i] &&
                             ((cmp_en && (ent_addr[i] == cmp_addr)) ||
                              (sq_en  && (ent_seq[i] > sq_bound)));
    end

    // Lookup outcome and lowest free slot.
    always_comb begin
        hit_same  = 1'b0;
        hit_other = 1'b0;
        free_idx  = '0;
        full      = &ent_vld;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr_hit[i] && (ent_seq[i] == lk_seq)) hit_same  = 1'b1;
            if (addr_hit[i] && (ent_seq[i] != lk_seq)) hit_other = 1'b1;
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_vld[i]) free_idx = IDX_W'(i);
        end
    end

    // Entry state update: removal first, then allocation into a free slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_addr[i] <= '0;
                ent_seq[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (drop[i]) begin
                    ent_vld[i] <= 1'b0;
                end else if (alloc_en && (free_idx == IDX_W'(i))) begin
                    ent_vld[i]  <= 1'b1;
                    ent_addr[i] <= lk_addr;
                    ent_seq[i]  <= lk_seq;
                end
            end
        end
    end

endmodule

// File: rtl/adt_xlat_block.sv
// Per-thread translation-blocked flags, each with the sequence number of
// the instruction that waits on translation. Set wins over clear. A squash
// drops the flag when the waiting instruction lies beyond its boundary.
module adt_xlat_block #(
    parameter int NUM_THREADS = 2,
    parameter int SEQ_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic                   clr_en,
    input  logic [TID_W-1:0]       upd_tid,
    input  logic [SEQ_W-1:0]       set_seq,
    input  logic                   sq_en,
    input  logic [TID_W-1:0]       sq_tid,
    input  logic [SEQ_W-1:0]       sq_bound,
    output logic [NUM_THREADS-1:0] blocked
);
    logic [SEQ_W-1:0] wait_seq [NUM_THREADS];

    // Flag and waiting sequence number per thread.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                blocked[t]  <= 1'b0;
                wait_seq[t] <= '0;
            end else if (set_en && (upd_tid == TID_W'(t))) begin
                blocked[t]  <= 1'b1;
                wait_seq[t] <= set_seq;
            end else if (clr_en && (upd_tid == TID_W'(t))) begin
                blocked[t]  <= 1'b0;
            end else if (sq_en && (sq_tid == TID_W'(t)) && blocked[t] &&
                         (wait_seq[t] > sq_bound)) begin
                blocked[t]  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/addr_dep_tracker.sv
// Top of the address dependency tracker. It keeps one table per thread and
// a translation-blocked flag per thread. Each request gets grant or deny in
// the same cycle. Sequence numbers are compared as unsigned values and are
// assumed not to wrap while an entry is live.
module addr_dep_tracker
    import adt_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int DEPTH       = 4,
    parameter int ADDR_W      = 32,
    parameter int SEQ_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [SEQ_W-1:0]  req_seq,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fetch,
    output logic              grant,
    output logic              deny,
    input  logic              cmp_valid,
    input  logic [TID_W-1:0]  cmp_tid,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic              sq_valid,
    input  logic [TID_W-1:0]  sq_tid,
    input  logic [SEQ_W-1:0]  sq_seq,
    input  logic              sq_mem_stall,
    input  logic              xb_set,
    input  logic              xb_clr,
    input  logic [TID_W-1:0]  xb_tid,
    input  logic [SEQ_W-1:0]  xb_seq
);
    logic [NUM_THREADS-1:0] thr_hit_same;
    logic [NUM_THREADS-1:0] thr_hit_other;
    logic [NUM_THREADS-1:0] thr_full;
    logic [NUM_THREADS-1:0] thr_blocked;
    logic [SEQ_W-1:0]       eff_bound;
    logic                   sq_kill;
    logic                   alloc;
    adt_dec_e               dec;

    // Effective squash boundary: one higher for a memory-stall squash.
    assign eff_bound = sq_seq + SEQ_W'(sq_mem_stall);

    // A concurrent squash on the requesting thread removes this request.
    assign sq_kill = sq_valid && (sq_tid == req_tid) && (req_seq > eff_bound);

    // Request decision in priority order.
    always_comb begin
        dec = DEC_IDLE;
        if (req_valid) begin
            if (thr_blocked[req_tid])        dec = DEC_DENY_BLOCK;
            else if (sq_kill)                dec = DEC_DENY_SQUASH;
            else if (req_fetch)              dec = DEC_GRANT_FETCH;
            else if (thr_hit_same[req_tid])  dec = DEC_GRANT_REPLAY;
            else if (thr_hit_other[req_tid]) dec = DEC_DENY_CONFLICT;
            else if (thr_full[req_tid])      dec = DEC_DENY_FULL;
            else                             dec = DEC_GRANT_NEW;
        end
    end

    assign grant = dec_is_grant(dec);
    assign deny  = req_valid && !dec_is_grant(dec);
    assign alloc = (dec == DEC_GRANT_NEW);

    // One table per thread.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_tbl
        adt_thread_table #(
            .DEPTH (DEPTH),
            .ADDR_W(ADDR_W),
            .SEQ_W (SEQ_W)
        ) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_addr  (req_addr),
            .lk_seq   (req_seq),
            .hit_same (thr_hit_same[t]),
            .hit_other(thr_hit_other[t]),
            .full     (thr_full[t]),
            .alloc_en (alloc && (req_tid == TID_W'(t))),
            .cmp_en   (cmp_valid && (cmp_tid == TID_W'(t))),
            .cmp_addr (cmp_addr),
            .sq_en    (sq_valid && (sq_tid == TID_W'(t))),
            .sq_bound (eff_bound)
        );
    end

    adt_xlat_block #(
        .NUM_THREADS(NUM_THREADS),
        .SEQ_W      (SEQ_W)
    ) u_xlat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (xb_set),
        .clr_en  (xb_clr),
        .upd_tid (xb_tid),
        .set_seq (xb_seq),
        .sq_en   (sq_valid),
        .sq_tid  (sq_tid),
        .sq_bound(eff_bound),
        .blocked (thr_blocked)
    );

endmodule

// File: rtl/adt_checker.sv
// Property checks for addr_dep_tracker. They are attached with bind and
// observe ports together with the per-thread flag and lookup vectors.
module adt_checker #(
    parameter int NUM_THREADS = 2,
    parameter int ADDR_W      = 32,
    parameter int SEQ_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [TID_W-1:0]       req_tid,
    input logic [SEQ_W-1:0]       req_seq,
    input logic [ADDR_W-1:0]      req_addr,
    input logic                   req_fetch,
    input logic                   grant,
    input logic                   deny,
    input logic                   cmp_valid,
    input logic                   sq_valid,
    input logic                   sq_kill,
    input logic [NUM_THREADS-1:0] thr_blocked,
    input logic [NUM_THREADS-1:0] thr_hit_same
);
    logic past_ok;

    // Marks that one full cycle has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || deny) == req_valid && !(grant && deny));

    // R2
    same_addr_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(req_valid && grant && !req_fetch && !cmp_valid && !sq_valid) &&
         req_valid && !req_fetch && (req_tid == $past(req_tid)) &&
         (req_addr == $past(req_addr)) && (req_seq != $past(req_seq))) |-> deny);

    // R3
    replay_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_fetch && !thr_blocked[req_tid] && !sq_kill &&
         thr_hit_same[req_tid]) |-> grant);

    // R5
    fetch_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch && !thr_blocked[req_tid] && !sq_kill) |-> grant);

    // R10
    blocked_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && thr_blocked[req_tid]) |-> deny);

endmodule

bind addr_dep_tracker adt_checker #(
    .NUM_THREADS(NUM_THREADS),
    .ADDR_W     (ADDR_W),
    .SEQ_W      (SEQ_W)
) u_adt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_tid     (req_tid),
    .req_seq     (req_seq),
    .req_addr    (req_addr),
    .req_fetch   (req_fetch),
    .grant       (grant),
    .deny        (deny),
    .cmp_valid   (cmp_valid),
    .sq_valid    (sq_valid),
    .sq_kill     (sq_kill),
    .thr_blocked (thr_blocked),
    .thr_hit_same(thr_hit_same)
);

// File: tb/tb_addr_dep_tracker.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected response of each cycle
// into a queue, and a monitor pops the entry and compares it once the
// combinational outputs have settled.
module tb_addr_dep_tracker;
    localparam int TID_W  = 1;
    localparam int ADDR_W = 32;
    localparam int SEQ_W  = 16;

    typedef struct {
        logic  exp_grant;
        logic  exp_deny;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [TID_W-1:0]  req_tid = '0;
    logic [SEQ_W-1:0]  req_seq = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_fetch = 1'b0;
    logic              grant, deny;
    logic              cmp_valid = 1'b0;
    logic [TID_W-1:0]  cmp_tid = '0;
    logic [ADDR_W-1:0] cmp_addr = '0;
    logic              sq_valid = 1'b0;
    logic [TID_W-1:0]  sq_tid = '0;
    logic [SEQ_W-1:0]  sq_seq = '0;
    logic              sq_mem_stall = 1'b0;
    logic              xb_set = 1'b0;
    logic              xb_clr = 1'b0;
    logic [TID_W-1:0]  xb_tid = '0;
    logic [SEQ_W-1:0]  xb_seq = '0;

    exp_t scb_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #2.5 clk = ~clk;

    addr_dep_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tid(req_tid), .req_seq(req_seq),
        .req_addr(req_addr), .req_fetch(req_fetch),
        .grant(grant), .deny(deny),
        .cmp_valid(cmp_valid), .cmp_tid(cmp_tid), .cmp_addr(cmp_addr),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .sq_mem_stall(sq_mem_stall),
        .xb_set(xb_set), .xb_clr(xb_clr), .xb_tid(xb_tid), .xb_seq(xb_seq)
    );

    // Side-channel setters: they take effect in the next driven cycle.
    task automatic complete(input int tid, input int addr);
        cmp_valid = 1'b1; cmp_tid = TID_W'(tid); cmp_addr = ADDR_W'(addr);
    endtask

    task automatic squash(input int tid, input int s, input bit ms);
        sq_valid = 1'b1; sq_tid = TID_W'(tid); sq_seq = SEQ_W'(s); sq_mem_stall = ms;
    endtask

    task automatic block(input int tid, input int s);
        xb_set = 1'b1; xb_tid = TID_W'(tid); xb_seq = SEQ_W'(s);
    endtask

    task automatic unblock(input int tid);
        xb_clr = 1'b1; xb_tid = TID_W'(tid);
    endtask

    // Drives one cycle, pushes the expected response, then clears all pulses.
    task automatic cyc(input bit rv, input int tid, input int s, input int addr,
                       input bit fetch, input bit exp_g, input string tag);
        exp_t e;
        @(negedge clk);
        #0.5;
        req_valid = rv; req_tid = TID_W'(tid); req_seq = SEQ_W'(s);
        req_addr = ADDR_W'(addr); req_fetch = fetch;
        e.exp_grant = rv && exp_g;
        e.exp_deny  = rv && !exp_g;
        e.tag       = tag;
        scb_q.push_back(e);
        @(posedge clk);
        #0.5;
        req_valid = 1'b0; cmp_valid = 1'b0; sq_valid = 1'b0;
        sq_mem_stall = 1'b0; xb_set = 1'b0; xb_clr = 1'b0;
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 0, 0, 0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compares the settled outputs of each driven cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (scb_q.size() > 0) begin
                exp_t e;
                e = scb_q.pop_front();
                n_checks++;
                if (grant !== e.exp_grant || deny !== e.exp_deny) begin
                    n_fail++;
                    $display("FAIL %s: grant/deny=%b%b expected %b%b",
                             e.tag, grant, deny, e.exp_grant, e.exp_deny);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5;
        cyc(1'b0, 0, 0, 0, 1'b0, 1'b0, "R1 reset idle");
        rst_n = 1'b1;
        idle("R1 idle after reset");

        // Basic conflict, replay, and per-thread tables.
        cyc(1, 0, 10, 'h100, 0, 1, "R1 first data grant");
        cyc(1, 0, 11, 'h100, 0, 0, "R2 same addr other seq");
        cyc(1, 0, 10, 'h100, 0, 1, "R3 replay same seq");
        cyc(1, 1, 11, 'h100, 0, 1, "R4 other thread same addr");
        cyc(1, 0, 12, 'h100, 1, 1, "R5 fetch bypasses conflict");

        // Fetch creates no entry.
        cyc(1, 1, 12, 'h700, 1, 1, "R5 fetch grant");
        cyc(1, 1, 13, 'h700, 0, 1, "R5 fetch left no entry");
        complete(1, 'h700);
        idle("R6 completion cycle");

        // Completion frees the address.
        complete(0, 'h100);
        idle("R6 completion cycle");
        cyc(1, 0, 13, 'h100, 0, 1, "R6 freed address granted");

        // Fill thread 0: entries 13,14,15,16.
        cyc(1, 0, 14, 'h104, 0, 1, "R7 fill");
        cyc(1, 0, 15, 'h108, 0, 1, "R7 fill");
        cyc(1, 0, 16, 'h10c, 0, 1, "R7 fill");
        cyc(1, 0, 17, 'h110, 0, 0, "R7 full table deny");
        cyc(1, 0, 17, 'h110, 1, 1, "R5 fetch with full table");
        cyc(1, 0, 15, 'h108, 0, 1, "R3 replay while full");

        // Squash with boundary 14 removes 15 and 16.
        squash(0, 14, 0);
        idle("R8 squash cycle");
        cyc(1, 0, 20, 'h108, 0, 1, "R8 younger entry removed");
        cyc(1, 0, 21, 'h104, 0, 0, "R8 boundary owner kept");

        // Memory-stall squash with S=19 keeps owner 20.
        squash(0, 19, 1);
        idle("R9 stall squash cycle");
        cyc(1, 0, 22, 'h108, 0, 0, "R9 S+1 owner survives");
        squash(0, 19, 0);
        idle("R8 plain squash cycle");
        cyc(1, 0, 23, 'h108, 0, 1, "R8 owner 20 removed");

        // Translation block on thread 1.
        block(1, 30);
        idle("R10 block set cycle");
        cyc(1, 1, 31, 'h200, 0, 0, "R10 blocked data deny");
        cyc(1, 1, 31, 'h200, 1, 0, "R10 blocked fetch deny");
        cyc(1, 0, 24, 'h300, 0, 1, "R10 other thread unaffected");
        squash(1, 29, 0);
        idle("R11 squash beyond waiter");
        cyc(1, 1, 31, 'h200, 0, 1, "R11 flag cleared by squash");
        cyc(1, 1, 11, 'h100, 0, 1, "R8 older entry kept by squash");

        block(1, 40);
        idle("R10 block set cycle");
        squash(1, 45, 0);
        idle("R11 squash not reaching waiter");
        cyc(1, 1, 41, 'h204, 0, 0, "R11 flag kept");
        unblock(1);
        idle("R10 clear cycle");
        cyc(1, 1, 42, 'h204, 0, 1, "R10 clear restores grants");
        block(1, 50);
        unblock(1);
        idle("R10 set and clear together");
        cyc(1, 1, 43, 'h208, 0, 0, "R10 set wins over clear");
        unblock(1);
        idle("R10 clear cycle");

        // Thread 0 holds 13,14,23,24. Completion and squash both hit 24.
        complete(0, 'h300);
        squash(0, 23, 0);
        idle("R12 combined removal cycle");
        cyc(1, 0, 50, 'h300, 0, 1, "R12 entry removed");
        cyc(1, 0, 51, 'h400, 0, 0, "R12 exactly one slot freed");
        cyc(1, 0, 52, 'h104, 0, 0, "R12 other entry untouched");
        cyc(1, 0, 23, 'h108, 0, 1, "R12 owner 23 untouched");

        // Request during a squash of its own thread: thread 1 holds 11,31,42.
        squash(1, 55, 0);
        cyc(1, 1, 60, 'h500, 0, 0, "R13 squashed request denied");
        cyc(1, 1, 61, 'h500, 0, 1, "R13 squashed request not recorded");
        squash(1, 55, 0);
        cyc(1, 1, 55, 'h504, 0, 0, "R7 full after R13 fill");
        cyc(1, 1, 12, 'h100, 0, 0, "R4 thread 1 conflict");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule